// File: doc/BRIEF.md
# Cache Flash-Invalidate Sequencer

This block owns the per-line status storage of a write-through cache whose ways can each be set aside as directly addressed SRAM. Software writes a self-clearing invalidate control bit. The block then walks the set index from the lowest to the highest set, one set per clock. At each set it clears the four status bits of every way that is in cache mode. Ways flagged as SRAM keep their status untouched. The control bit reads back as 1 for the whole walk and then drops by itself, and a one-cycle done pulse follows. While the walk runs, every bus request is answered with a retry instead of an acknowledge. Status updates and lookups have no effect during that time.

Outside a walk, the block resolves lookups. A hit needs a tag match, a valid line and a clean tag parity check. A tag parity error is reported and treated as a miss. It leaves the line's status alone, so only a full walk removes the faulty line. The block also tracks ECC error reports from the data path. It keeps the address of the first report until software clears it, and a later report sets an overflow flag instead. Single-bit reports are counted in a saturating counter that is compared with a programmable threshold. That counter returns to zero when a walk completes.

Top module: `cache_flush_seq`

## Requirements
- R1: A cycle with `ctl_wr`=1 and `ctl_inv`=1 while idle sets `inv_busy` from the next cycle on. `inv_busy` stays 1 for exactly NUM_SETS cycles and then returns to 0 without any software action.
- R2: `inv_done` is 1 for exactly one cycle, the first cycle in which `inv_busy` is 0 again after a walk.
- R3: After a walk, every way whose bit in `sram_way_mask` is 0 reads status 4'b0000 at every set. The status bit order is valid (bit 3), instruction-locked (bit 2), data-locked (bit 1), stale (bit 0).
- R4: After a walk, every way whose `sram_way_mask` bit is 1 reads the same status it had before the walk, at every set.
- R5: In a cycle with `bus_req`=1, the combinational outputs are `bus_retry`=1 and `bus_ack`=0 while `inv_busy` is 1, and `bus_retry`=0 and `bus_ack`=1 otherwise.
- R6: A write of 1 to the invalidate bit during a walk is ignored. The walk keeps its original length of NUM_SETS busy cycles.
- R7: A lookup with `lk_tag_perr`=1 gives `lk_hit`=0 and `lk_perr`=1, and the addressed line keeps its status. Otherwise, while idle, `lk_hit` = `lk_tag_match` AND the valid bit of the addressed line.
- R8: The first ECC report (`ecc_evt`=1) while `err_addr_vld`=0 loads `err_addr` and sets `err_addr_vld`. Further reports leave `err_addr` unchanged and set `err_ovf`. `err_clr` clears `err_addr_vld` and `err_ovf`.
- R9: Each report with `ecc_single`=1 increments `sbe_count`, which saturates at 2^CNT_W-1. `sbe_over` is 1 exactly when `sbe_count` > `sbe_thresh`.
- R10: `sbe_count` is 0 when `inv_done` is asserted.
- R11: A status write (`upd_en`=1) performed while idle loads the addressed line. A status write during a walk has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_inv | input | 1 | Write data of the invalidate bit |
| inv_busy | output | 1 | Invalidate bit read-back, 1 during a walk |
| inv_done | output | 1 | One-cycle pulse after the walk ends |
| sram_way_mask | input | NUM_WAYS | 1 marks a way as SRAM |
| bus_req | input | 1 | Incoming bus transaction |
| bus_retry | output | 1 | Retry response |
| bus_ack | output | 1 | Service response |
| upd_en | input | 1 | Line status write |
| upd_set | input | SET_W | Set of the status write |
| upd_way | input | WAY_W | Way of the status write |
| upd_stat | input | 4 | New status {valid, ilock, dlock, stale} |
| rd_set | input | SET_W | Set of the status read |
| rd_way | input | WAY_W | Way of the status read |
| rd_stat | output | 4 | Status of the read line |
| lk_req | input | 1 | Lookup request |
| lk_set | input | SET_W | Lookup set |
| lk_way | input | WAY_W | Way whose tag compared equal |
| lk_tag_match | input | 1 | Tag comparison result |
| lk_tag_perr | input | 1 | Tag parity error on the lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_perr | output | 1 | Tag parity error report |
| ecc_evt | input | 1 | ECC error report |
| ecc_single | input | 1 | Report is a single-bit error |
| ecc_addr | input | ADDR_W | Address of the reported error |
| err_clr | input | 1 | Clears the captured error address |
| sbe_thresh | input | CNT_W | Single-bit error threshold |
| err_addr | output | ADDR_W | Captured error address |
| err_addr_vld | output | 1 | Captured address valid |
| err_ovf | output | 1 | A report arrived while an address was held |
| sbe_count | output | CNT_W | Saturating single-bit error count |
| sbe_over | output | 1 | Count above threshold |

## Verification
The walk is run with all sixteen SRAM masks of a four-way, eight-set configuration. Before each walk, every line gets a nonzero pattern computed from its set, way and round. Reading all lines back separates a cleared cache way from a preserved SRAM way and catches a wrong or skipped index. The busy length is counted both with and without a second start write in mid-walk, which distinguishes a restart from an ignored write. The error counter is driven past saturation with every threshold value compared at each count. Lookups are tried with and without tag parity errors, and the line is read back afterwards.

// File: rtl/cfs_pkg.sv
// Shared types of the flash-invalidate sequencer.
// Assumes: status bit order {valid, ilock, dlock, stale}, MSB first.
package cfs_pkg;
    typedef struct packed {
        logic valid;
        logic ilock;
        logic dlock;
        logic stale;
    } line_stat_t;
endpackage

// File: rtl/cfs_walk_ctrl.sv
// Walk controller: accepts a start request while idle, steps a set index
// from 0 to NUM_SETS-1 (one per clock) and raises a done pulse after the
// last index. Assumes NUM_SETS >= 2. Starts during a walk are ignored.
module cfs_walk_ctrl #(
    parameter int NUM_SETS = 8,
    localparam int SET_W = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    output logic             busy,
    output logic [SET_W-1:0] walk_idx,
    output logic             walk_last,
    output logic             done
);
    localparam logic [SET_W-1:0] LAST_IDX = SET_W'(NUM_SETS - 1);

    assign walk_last = busy && (walk_idx == LAST_IDX);

    // Purpose: sequence idle -> walk -> done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            walk_idx <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start_req) begin
                    busy     <= 1'b1;
                    walk_idx <= '0;
                end
            end else if (walk_last) begin
                busy     <= 1'b0;
                walk_idx <= '0;
                done     <= 1'b1;
            end else begin
                walk_idx <= walk_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfs_stat_array.sv
// Line status storage, one column per way. A clear at clr_idx zeroes the
// cache-mode ways of that set; SRAM ways are not written. Writes from the
// update port are accepted only when no clear is active. Two read ports.
module cfs_stat_array
    import cfs_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_en,
    input  logic [SET_W-1:0]    clr_idx,
    input  logic [NUM_WAYS-1:0] sram_mask,
    input  logic                wr_en,
    input  logic [SET_W-1:0]    wr_set,
    input  logic [WAY_W-1:0]    wr_way,
    input  line_stat_t          wr_stat,
    input  logic [SET_W-1:0]    ra_set,
    input  logic [WAY_W-1:0]    ra_way,
    output line_stat_t          ra_stat,
    input  logic [SET_W-1:0]    rb_set,
    input  logic [WAY_W-1:0]    rb_way,
    output line_stat_t          rb_stat
);
    line_stat_t ra_col [NUM_WAYS];
    line_stat_t rb_col [NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        line_stat_t col [NUM_SETS];

        // Purpose: reset, walk clear (cache ways only) or status write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < NUM_SETS; s++) col[s] <= '0;
            end else if (clr_en) begin
                if (!sram_mask[w]) col[clr_idx] <= '0;
            end else if (wr_en && (wr_way == WAY_W'(w))) begin
                col[wr_set] <= wr_stat;
            end
        end

        assign ra_col[w] = col[ra_set];
        assign rb_col[w] = col[rb_set];
    end

    assign ra_stat = ra_col[ra_way];
    assign rb_stat = rb_col[rb_way];
endmodule

// File: rtl/cfs_err_track.sv
// ECC error tracking: holds the first reported address until cleared
// (later reports set overflow), and counts single-bit reports with
// saturation. The counter is zeroed by cnt_rst, which wins over a report.
module cfs_err_track #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_evt,
    input  logic              ecc_single,
    input  logic [ADDR_W-1:0] ecc_addr,
    input  logic              err_clr,
    input  logic              cnt_rst,
    input  logic [CNT_W-1:0]  thresh,
    output logic [ADDR_W-1:0] err_addr,
    output logic              err_vld,
    output logic              err_ovf,
    output logic [CNT_W-1:0]  sbe_cnt,
    output logic              sbe_over
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Purpose: capture first error address, flag overflow, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_addr <= '0;
            err_vld  <= 1'b0;
            err_ovf  <= 1'b0;
        end else if (err_clr) begin
            err_vld <= 1'b0;
            err_ovf <= 1'b0;
        end else if (ecc_evt) begin
            if (!err_vld) begin
                err_addr <= ecc_addr;
                err_vld  <= 1'b1;
            end else begin
                err_ovf <= 1'b1;
            end
        end
    end

    // Purpose: saturating single-bit error counter, zeroed at walk end.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_rst) begin
            sbe_cnt <= '0;
        end else if (ecc_evt && ecc_single && (sbe_cnt != CNT_MAX)) begin
            sbe_cnt <= sbe_cnt + 1'b1;
        end
    end

    assign sbe_over = (sbe_cnt > thresh);
endmodule

// File: rtl/cache_flush_seq.sv
// Top of the flash-invalidate sequencer. Starts a status walk on a write
// of 1 to the invalidate bit, retries bus traffic and blocks status writes
// while walking, resolves lookups (parity errors force a miss) and tracks
// ECC errors. Assumes NUM_SETS and NUM_WAYS are powers of two >= 2.
module cache_flush_seq
    import cfs_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 3,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic                ctl_inv,
    output logic                inv_busy,
    output logic                inv_done,
    input  logic [NUM_WAYS-1:0] sram_way_mask,
    input  logic                bus_req,
    output logic                bus_retry,
    output logic                bus_ack,
    input  logic                upd_en,
    input  logic [SET_W-1:0]    upd_set,
    input  logic [WAY_W-1:0]    upd_way,
    input  logic [3:0]          upd_stat,
    input  logic [SET_W-1:0]    rd_set,
    input  logic [WAY_W-1:0]    rd_way,
    output logic [3:0]          rd_stat,
    input  logic                lk_req,
    input  logic [SET_W-1:0]    lk_set,
    input  logic [WAY_W-1:0]    lk_way,
    input  logic                lk_tag_match,
    input  logic                lk_tag_perr,
    output logic                lk_hit,
    output logic                lk_perr,
    input  logic                ecc_evt,
    input  logic                ecc_single,
    input  logic [ADDR_W-1:0]   ecc_addr,
    input  logic                err_clr,
    input  logic [CNT_W-1:0]    sbe_thresh,
    output logic [ADDR_W-1:0]   err_addr,
    output logic                err_addr_vld,
    output logic                err_ovf,
    output logic [CNT_W-1:0]    sbe_count,
    output logic                sbe_over
);
    logic             walk_last;
    logic [SET_W-1:0] walk_idx;
    line_stat_t       rd_line;
    line_stat_t       lk_line;

    cfs_walk_ctrl #(.NUM_SETS(NUM_SETS)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (ctl_wr && ctl_inv),
        .busy      (inv_busy),
        .walk_idx  (walk_idx),
        .walk_last (walk_last),
        .done      (inv_done)
    );

    cfs_stat_array #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en    (inv_busy),
        .clr_idx   (walk_idx),
        .sram_mask (sram_way_mask),
        .wr_en     (upd_en && !inv_busy),
        .wr_set    (upd_set),
        .wr_way    (upd_way),
        .wr_stat   (line_stat_t'(upd_stat)),
        .ra_set    (rd_set),
        .ra_way    (rd_way),
        .ra_stat   (rd_line),
        .rb_set    (lk_set),
        .rb_way    (lk_way),
        .rb_stat   (lk_line)
    );

    cfs_err_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .ecc_evt    (ecc_evt),
        .ecc_single (ecc_single),
        .ecc_addr   (ecc_addr),
        .err_clr    (err_clr),
        .cnt_rst    (walk_last),
        .thresh     (sbe_thresh),
        .err_addr   (err_addr),
        .err_vld    (err_addr_vld),
        .err_ovf    (err_ovf),
        .sbe_cnt    (sbe_count),
        .sbe_over   (sbe_over)
    );

    // Purpose: bus responses and lookup resolution.
    always_comb begin
        bus_retry = bus_req && inv_busy;
        bus_ack   = bus_req && !inv_busy;
        lk_perr   = lk_req && lk_tag_perr;
        lk_hit    = lk_req && !inv_busy && lk_tag_match && !lk_tag_perr
                    && lk_line.valid;
        rd_stat   = rd_line;
    end
endmodule

// File: rtl/cache_flush_seq_chk.sv
// Assertion checker for cache_flush_seq, attached by bind below.
module cache_flush_seq_chk #(
    parameter int NUM_SETS = 8,
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic              ctl_inv,
    input logic              inv_busy,
    input logic              inv_done,
    input logic              bus_req,
    input logic              bus_retry,
    input logic              bus_ack,
    input logic              lk_req,
    input logic              lk_tag_perr,
    input logic              lk_hit,
    input logic              lk_perr,
    input logic              err_clr,
    input logic [ADDR_W-1:0] err_addr,
    input logic              err_addr_vld,
    input logic [CNT_W-1:0]  sbe_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    int busy_run;

    // Purpose: count consecutive busy cycles before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_run <= 0;
        else if (inv_busy) busy_run <= busy_run + 1;
        else               busy_run <= 0;
    end

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_inv && !inv_busy) |=> inv_busy);
    // R1 R6
    walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_busy |-> (busy_run < NUM_SETS));
    // R2
    done_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |-> (!inv_busy && $past(inv_busy)));
    // R5
    retry_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && inv_busy) |-> (bus_retry && !bus_ack));
    // R7
    perr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_tag_perr) |-> (!lk_hit && lk_perr));
    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_addr_vld && !err_clr) |=> (err_addr_vld && $stable(err_addr)));
    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_count == CNT_MAX && !inv_busy) |=> (sbe_count == CNT_MAX));
    // R10
    cnt_zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |-> (sbe_count == '0));
endmodule

bind cache_flush_seq cache_flush_seq_chk #(
    .NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/cache_flush_seq_tb.sv
`timescale 1ns/1ps
module cache_flush_seq_tb;
    localparam int NS = 8;
    localparam int NW = 4;
    localparam int AW = 12;
    localparam int CW = 3;

    logic clk = 0, rst_n = 0;
    logic ctl_wr = 0, ctl_inv = 0, inv_busy, inv_done;
    logic [NW-1:0] sram_way_mask = '0;
    logic bus_req = 0, bus_retry, bus_ack;
    logic upd_en = 0;
    logic [2:0] upd_set = 0, rd_set = 0, lk_set = 0;
    logic [1:0] upd_way = 0, rd_way = 0, lk_way = 0;
    logic [3:0] upd_stat = 0, rd_stat;
    logic lk_req = 0, lk_tag_match = 0, lk_tag_perr = 0, lk_hit, lk_perr;
    logic ecc_evt = 0, ecc_single = 0, err_clr = 0;
    logic [AW-1:0] ecc_addr = 0, err_addr;
    logic [CW-1:0] sbe_thresh = 0, sbe_count;
    logic err_addr_vld, err_ovf, sbe_over;

    int n_chk = 0, n_bad = 0;
    int model [NS][NW];

    always #2.5 clk = ~clk;

    cache_flush_seq #(.NUM_SETS(NS), .NUM_WAYS(NW), .ADDR_W(AW), .CNT_W(CW)) u_dut (.*);

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_line(int s, int w, int v);
        @(negedge clk);
        upd_en = 1; upd_set = 3'(s); upd_way = 2'(w); upd_stat = 4'(v);
        @(negedge clk);
        upd_en = 0;
    endtask

    task automatic rd_line(int s, int w, output int v);
        rd_set = 3'(s); rd_way = 2'(w);
        #1 v = int'(rd_stat);
    endtask

    // Start a walk; optionally rewrite the start bit and a status line mid-walk.
    task automatic flush(bit again, bit poke);
        int n;
        @(negedge clk);
        ctl_wr = 1; ctl_inv = 1;
        @(negedge clk);
        ctl_wr = 0;
        n = 0;
        while (inv_busy === 1'b1 && n < 100) begin
            ctl_wr = (again && n == 3);
            upd_en = (poke && n == 1);
            upd_set = 0; upd_way = 0; upd_stat = 4'd9;
            bus_req = 1;
            #1;
            check("R5 retry in walk", int'(bus_retry), 1);
            check("R5 no ack in walk", int'(bus_ack), 0);
            bus_req = 0;
            @(negedge clk);
            n++;
        end
        ctl_wr = 0; upd_en = 0;
        check(again ? "R6 busy length with rewrite" : "R1 busy length", n, NS);
        check("R2 done pulse", int'(inv_done), 1);
        check("R10 count zero at done", int'(sbe_count), 0);
        @(negedge clk);
        check("R2 done one cycle", int'(inv_done), 0);
        check("R1 bit self-cleared", int'(inv_busy), 0);
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int v, e;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        check("R1 idle after reset", int'(inv_busy), 0);
        check("R8 no address after reset", int'(err_addr_vld), 0);
        check("R9 count zero after reset", int'(sbe_count), 0);
        rd_line(5, 3, v);
        check("R3 status zero after reset", v, 0);
        bus_req = 1; #1;
        check("R5 ack when idle", int'(bus_ack), 1);
        check("R5 no retry when idle", int'(bus_retry), 0);
        bus_req = 0;

        // R3 R4 R11: all SRAM masks, nonzero patterns
        for (int m = 0; m < 16; m++) begin
            sram_way_mask = 4'(m);
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++) begin
                    model[s][w] = (s * 5 + w * 3 + m) % 15 + 1;
                    wr_line(s, w, model[s][w]);
                end
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++) begin
                    rd_line(s, w, v);
                    check("R11 write while idle", v, model[s][w]);
                end
            flush(m == 5, 0);
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++) begin
                    e = m[w] ? model[s][w] : 0;
                    rd_line(s, w, v);
                    check(m[w] ? "R4 SRAM way kept" : "R3 cache way cleared", v, e);
                end
        end

        // R11: write during walk ignored (way 0 kept as SRAM)
        sram_way_mask = 4'b0001;
        wr_line(0, 0, 5);
        flush(0, 1);
        rd_line(0, 0, v);
        check("R11 write in walk ignored", v, 5);

        // R7: lookups
        sram_way_mask = 4'b0000;
        wr_line(2, 1, 4'b1000);
        wr_line(3, 1, 4'b0110);
        lk_req = 1; lk_set = 2; lk_way = 1; lk_tag_match = 1; lk_tag_perr = 0;
        #1 check("R7 hit on valid match", int'(lk_hit), 1);
        lk_tag_match = 0;
        #1 check("R7 miss on no match", int'(lk_hit), 0);
        lk_set = 3; lk_tag_match = 1;
        #1 check("R7 miss on invalid line", int'(lk_hit), 0);
        lk_set = 2; lk_tag_perr = 1;
        #1 check("R7 parity forces miss", int'(lk_hit), 0);
        check("R7 parity reported", int'(lk_perr), 1);
        @(negedge clk);
        lk_req = 0; lk_tag_perr = 0;
        rd_line(2, 1, v);
        check("R7 parity keeps line", v, 8);
        flush(0, 0);
        lk_req = 1; lk_tag_match = 1;
        #1 check("R7 miss after walk", int'(lk_hit), 0);
        lk_req = 0; lk_tag_match = 0;

        // R8: error address capture
        @(negedge clk);
        ecc_evt = 1; ecc_single = 0; ecc_addr = 12'h3A5;
        @(negedge clk);
        ecc_addr = 12'h0C7;
        check("R8 first address", int'(err_addr), 12'h3A5);
        check("R8 valid set", int'(err_addr_vld), 1);
        check("R8 no overflow yet", int'(err_ovf), 0);
        @(negedge clk);
        ecc_evt = 0;
        check("R8 address kept", int'(err_addr), 12'h3A5);
        check("R8 overflow set", int'(err_ovf), 1);
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;
        check("R8 cleared valid", int'(err_addr_vld), 0);
        check("R8 cleared overflow", int'(err_ovf), 0);
        ecc_evt = 1; ecc_addr = 12'h111;
        @(negedge clk);
        ecc_evt = 0;
        check("R8 recapture", int'(err_addr), 12'h111);
        check("R9 non-single not counted", int'(sbe_count), 0);

        // R9: saturation and threshold sweep
        for (int k = 1; k <= 10; k++) begin
            ecc_evt = 1; ecc_single = 1;
            @(negedge clk);
            ecc_evt = 0; ecc_single = 0;
            e = (k > 7) ? 7 : k;
            check("R9 count", int'(sbe_count), e);
            for (int t = 0; t < 8; t++) begin
                sbe_thresh = 3'(t);
                #0.1 check("R9 over threshold", int'(sbe_over), (e > t) ? 1 : 0);
            end
        end
        // R10: walk zeroes the count
        flush(0, 0);
        check("R10 count zero after walk", int'(sbe_count), 0);

        finish_up();
    end
endmodule